// File: doc/BRIEF.md
# Feedback Memory Command Throttler

This block caps the average power a memory device draws by deciding, cycle by cycle, whether the controller may send a queued command. Time is cut into windows of a fixed length. Each window opens with an active phase, in which commands may go out, and closes with a stall phase, in which they wait in the controller. The number of active cycles per window is the active length.

Over each window the block counts read, write and bank-conflict strobes. When the window closes, it forms a power estimate from those counts, a constant base term and one weight per event kind. It subtracts the estimate from a power budget and scales the difference by a loop gain. It adds the result to the active length and clips it to a legal range. The new length governs the window that follows. The budget, the gain and the model weights are inputs held by the surrounding logic.

Top module: `thr_cmd_throttle`

## Requirements
- R1: A window lasts WIN_LEN cycles and begins in the first cycle after reset is released. Window cycles are numbered from 0. Cycles with index below the active length are active and the rest are stalled.
- R2: `issue_en_o` is high exactly when `cmd_valid_i` is high and the current cycle is active. During stall it stays low whatever `cmd_valid_i` does.
- R3: The estimate is w_base + w_rd·reads + w_wr·writes + w_conf·conflicts. Each count is the number of cycles in the window whose strobe of that kind was high, and a strobe in the last cycle of a window counts toward that window. Counts begin again from zero in every window.
- R4: At each window end the new length is old length + floor(((budget − estimate) · gain) / 2^GAIN_FRAC), using signed arithmetic. A positive error lengthens the active phase and a negative one shortens it.
- R5: The active length is clipped to the range MIN_ACT to WIN_LEN inclusive.
- R6: `act_len_o` changes only on the edge that closes a window, and its new value governs the next window from cycle 0.
- R7: During reset, and in the first window after it, the active length equals WIN_LEN. Event strobes seen while reset is high are not counted.
- R8: Strobes of different kinds that are high in the same cycle are each counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | A command is waiting to issue |
| rd_evt_i | input | 1 | A read was sent this cycle |
| wr_evt_i | input | 1 | A write was sent this cycle |
| conf_evt_i | input | 1 | A bank conflict occurred this cycle |
| pwr_budget_i | input | PWR_W | Power setpoint in estimate units |
| loop_gain_i | input | GAIN_W | Loop gain, unsigned, GAIN_FRAC fraction bits |
| w_base_i | input | COEF_W | Constant term of the estimate |
| w_rd_i | input | COEF_W | Weight per read |
| w_wr_i | input | COEF_W | Weight per write |
| w_conf_i | input | COEF_W | Weight per bank conflict |
| issue_en_o | output | 1 | Command may issue this cycle |
| act_len_o | output | LEN_W | Active length of the current window |

## Verification
Two functions meet in the last cycle of a window: an event strobe must still be counted, and the count, the new estimate and the new active length are all settled on the same edge. The bench drives read strobes in the final cycles of several windows, including a window whose only event sits in that last cycle. It then judges the active length shown in cycle 0 of the next window against its own model. The change of length at the boundary is judged together with the gating: every cycle, `issue_en_o` is compared against the length the model expects for that window, so a length that arrives a cycle early or late shows up at the phase edge.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic {
        PH_ACTIVE = 1'b0,
        PH_STALL  = 1'b1
    } phase_e;

    localparam int EV_RD  = 0;
    localparam int EV_WR  = 1;
    localparam int EV_CF  = 2;
    localparam int N_EV   = 3;

    typedef logic signed [63:0] wide_t;

    function automatic wide_t clamp_wide(input wide_t v, input wide_t lo, input wide_t hi);
        wide_t r;
        if (v < lo)      r = lo;
        else if (v > hi) r = hi;
        else             r = v;
        return r;
    endfunction

    function automatic wide_t scale_floor(input wide_t v, input int unsigned sh);
        return v >>> sh;
    endfunction

endpackage

// File: rtl/thr_window_timer.sv
module thr_window_timer
    import thr_pkg::*;
#(
    parameter int WIN_LEN = 10000,
    parameter int LEN_W   = $clog2(WIN_LEN + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] act_len,
    output logic [LEN_W-1:0] pos,
    output logic             win_end,
    output phase_e           phase
);
    localparam logic [LEN_W-1:0] LAST = LEN_W'(WIN_LEN - 1);

    logic [LEN_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (pos_q == LAST)
            pos_q <= '0;
        else
            pos_q <= pos_q + LEN_W'(1);
    end

    assign pos     = pos_q;
    assign win_end = (pos_q == LAST);
    assign phase   = (pos_q < act_len) ? PH_ACTIVE : PH_STALL;

endmodule

// File: rtl/thr_event_counter.sv
module thr_event_counter
    import thr_pkg::*;
#(
    parameter int LEN_W = 14
)(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        win_end,
    input  logic [N_EV-1:0]             evt,
    output logic [N_EV-1:0][LEN_W-1:0]  cnt,
    output logic [N_EV-1:0][LEN_W-1:0]  snap
);
    for (genvar g = 0; g < N_EV; g++) begin : g_ev
        logic [LEN_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst || win_end)
                cnt_q <= '0;
            else if (evt[g])
                cnt_q <= cnt_q + LEN_W'(1);
        end

        assign cnt[g]  = cnt_q;
        assign snap[g] = cnt_q + LEN_W'(evt[g]);
    end

endmodule

// File: rtl/thr_power_loop.sv
module thr_power_loop
    import thr_pkg::*;
#(
    parameter int WIN_LEN   = 10000,
    parameter int MIN_ACT   = 100,
    parameter int COEF_W    = 12,
    parameter int GAIN_W    = 8,
    parameter int GAIN_FRAC = 4,
    parameter int PWR_W     = 32,
    parameter int LEN_W     = $clog2(WIN_LEN + 1)
)(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        win_end,
    input  logic [N_EV-1:0][LEN_W-1:0]  snap,
    input  logic [N_EV-1:0][COEF_W-1:0] w_ev,
    input  logic [COEF_W-1:0]           w_base,
    input  logic [PWR_W-1:0]            budget,
    input  logic [GAIN_W-1:0]           gain,
    output logic [LEN_W-1:0]            act_len
);
    localparam wide_t LO = wide_t'(MIN_ACT);
    localparam wide_t HI = wide_t'(WIN_LEN);

    wide_t term [N_EV];
    wide_t est;
    wide_t err;
    wide_t step;
    wide_t next_len;
    logic [LEN_W-1:0] act_q;

    for (genvar g = 0; g < N_EV; g++) begin : g_term
        assign term[g] = wide_t'(w_ev[g]) * wide_t'(snap[g]);
    end

    always_comb begin
        est = wide_t'(w_base);
        for (int i = 0; i < N_EV; i++)
            est = est + term[i];
        err      = wide_t'(budget) - est;
        step     = scale_floor(err * wide_t'(gain), GAIN_FRAC);
        next_len = clamp_wide(wide_t'(act_q) + step, LO, HI);
    end

    always_ff @(posedge clk) begin
        if (rst)
            act_q <= LEN_W'(WIN_LEN);
        else if (win_end)
            act_q <= next_len[LEN_W-1:0];
    end

    assign act_len = act_q;

endmodule

// File: rtl/thr_cmd_throttle.sv
module thr_cmd_throttle
    import thr_pkg::*;
#(
    parameter int WIN_LEN   = 10000,
    parameter int MIN_ACT   = 100,
    parameter int COEF_W    = 12,
    parameter int GAIN_W    = 8,
    parameter int GAIN_FRAC = 4,
    parameter int PWR_W     = 32,
    localparam int LEN_W    = $clog2(WIN_LEN + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid_i,
    input  logic              rd_evt_i,
    input  logic              wr_evt_i,
    input  logic              conf_evt_i,
    input  logic [PWR_W-1:0]  pwr_budget_i,
    input  logic [GAIN_W-1:0] loop_gain_i,
    input  logic [COEF_W-1:0] w_base_i,
    input  logic [COEF_W-1:0] w_rd_i,
    input  logic [COEF_W-1:0] w_wr_i,
    input  logic [COEF_W-1:0] w_conf_i,
    output logic              issue_en_o,
    output logic [LEN_W-1:0]  act_len_o
);
    logic [LEN_W-1:0]             win_pos;
    logic                         win_end;
    phase_e                       phase;
    logic [N_EV-1:0]              evt;
    logic [N_EV-1:0][COEF_W-1:0]  w_ev;
    logic [N_EV-1:0][LEN_W-1:0]   ev_cnt;
    logic [N_EV-1:0][LEN_W-1:0]   ev_snap;
    logic [LEN_W-1:0]             act_len;

    always_comb begin
        evt[EV_RD]  = rd_evt_i;
        evt[EV_WR]  = wr_evt_i;
        evt[EV_CF]  = conf_evt_i;
        w_ev[EV_RD] = w_rd_i;
        w_ev[EV_WR] = w_wr_i;
        w_ev[EV_CF] = w_conf_i;
    end

    thr_window_timer #(
        .WIN_LEN (WIN_LEN),
        .LEN_W   (LEN_W)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .act_len (act_len),
        .pos     (win_pos),
        .win_end (win_end),
        .phase   (phase)
    );

    thr_event_counter #(
        .LEN_W (LEN_W)
    ) count_i (
        .clk     (clk),
        .rst     (rst),
        .win_end (win_end),
        .evt     (evt),
        .cnt     (ev_cnt),
        .snap    (ev_snap)
    );

    thr_power_loop #(
        .WIN_LEN   (WIN_LEN),
        .MIN_ACT   (MIN_ACT),
        .COEF_W    (COEF_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC),
        .PWR_W     (PWR_W),
        .LEN_W     (LEN_W)
    ) loop_i (
        .clk     (clk),
        .rst     (rst),
        .win_end (win_end),
        .snap    (ev_snap),
        .w_ev    (w_ev),
        .w_base  (w_base_i),
        .budget  (pwr_budget_i),
        .gain    (loop_gain_i),
        .act_len (act_len)
    );

    assign issue_en_o = cmd_valid_i && (phase == PH_ACTIVE);
    assign act_len_o  = act_len;

endmodule

// File: rtl/thr_cmd_throttle_chk.sv
module thr_cmd_throttle_chk
    import thr_pkg::*;
#(
    parameter int WIN_LEN = 10000,
    parameter int MIN_ACT = 100,
    parameter int LEN_W   = $clog2(WIN_LEN + 1)
)(
    input logic                       clk,
    input logic                       rst,
    input logic                       cmd_valid_i,
    input logic                       issue_en_o,
    input logic [LEN_W-1:0]           act_len_o,
    input logic [LEN_W-1:0]           win_pos,
    input logic                       win_end,
    input logic [N_EV-1:0][LEN_W-1:0] ev_cnt
);
    assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (win_pos == '0));

    assert_pos_bound_R1: assert property (@(posedge clk) disable iff (rst)
        win_pos < LEN_W'(WIN_LEN));

    assert_need_valid_R2: assert property (@(posedge clk) disable iff (rst)
        issue_en_o |-> cmd_valid_i);

    assert_stall_block_R2: assert property (@(posedge clk) disable iff (rst)
        (win_pos >= act_len_o) |-> !issue_en_o);

    assert_count_clear_R3: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (ev_cnt == '0));

    assert_len_range_R5: assert property (@(posedge clk) disable iff (rst)
        (act_len_o >= LEN_W'(MIN_ACT)) && (act_len_o <= LEN_W'(WIN_LEN)));

    assert_len_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> $stable(act_len_o));

endmodule

bind thr_cmd_throttle thr_cmd_throttle_chk #(
    .WIN_LEN (WIN_LEN),
    .MIN_ACT (MIN_ACT),
    .LEN_W   (LEN_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid_i),
    .issue_en_o  (issue_en_o),
    .act_len_o   (act_len_o),
    .win_pos     (win_pos),
    .win_end     (win_end),
    .ev_cnt      (ev_cnt)
);

// File: tb/thr_cmd_throttle_tb_top.sv
module thr_cmd_throttle_tb_top;

    localparam int WIN  = 200;
    localparam int MINA = 20;
    localparam int CW   = 12;
    localparam int GW   = 8;
    localparam int GF   = 4;
    localparam int PW   = 32;
    localparam int LW   = $clog2(WIN + 1);
    localparam int W_BASE = 10;
    localparam int W_RD   = 3;
    localparam int W_WR   = 5;
    localparam int W_CF   = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          rd_evt = 1'b0;
    logic          wr_evt = 1'b0;
    logic          cf_evt = 1'b0;
    logic [PW-1:0] budget = '0;
    logic [GW-1:0] gain = '0;
    logic          issue_en;
    logic [LW-1:0] act_len;

    int    n_chk = 0;
    int    n_err = 0;
    int    exp_q[$];
    string tag_q[$];
    longint model_len = WIN;

    always #2 clk = ~clk;

    thr_cmd_throttle #(
        .WIN_LEN (WIN), .MIN_ACT (MINA), .COEF_W (CW),
        .GAIN_W (GW), .GAIN_FRAC (GF), .PWR_W (PW)
    ) dut_i (
        .clk (clk), .rst (rst), .cmd_valid_i (cmd_valid),
        .rd_evt_i (rd_evt), .wr_evt_i (wr_evt), .conf_evt_i (cf_evt),
        .pwr_budget_i (budget), .loop_gain_i (gain),
        .w_base_i (CW'(W_BASE)), .w_rd_i (CW'(W_RD)),
        .w_wr_i (CW'(W_WR)), .w_conf_i (CW'(W_CF)),
        .issue_en_o (issue_en), .act_len_o (act_len)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Driver: one window of stimulus, pushes the length expected for the next window.
    task automatic run_window(input int nr, input int nw, input int nc,
                              input int bud, input int g, input string req);
        longint est, err, nxt;
        budget = PW'(bud);
        gain   = GW'(g);
        for (int j = 0; j < WIN; j++) begin
            rd_evt    = (j >= WIN - nr);
            wr_evt    = (j < nw);
            cf_evt    = (j % 2 == 1) && (j / 2 < nc);
            cmd_valid = (j % 3 != 0);
            if (j == WIN - 1) begin
                est = W_BASE + W_RD * nr + W_WR * nw + W_CF * nc;
                err = longint'(bud) - est;
                nxt = model_len + ((err * g) >>> GF);
                if (nxt < MINA) nxt = MINA;
                if (nxt > WIN)  nxt = WIN;
                model_len = nxt;
                exp_q.push_back(int'(nxt));
                tag_q.push_back(req);
            end
            @(negedge clk);
        end
    endtask

    // Monitor: tracks the window position and compares against the scoreboard.
    int    mon_pos = 0;
    int    cur_len = WIN;
    string cur_tag = "R7";
    always begin
        @(negedge clk);
        #1;
        if (rst) begin
            mon_pos = 0;
        end else begin
            if (mon_pos == 0 && exp_q.size() > 0) begin
                cur_len = exp_q.pop_front();
                cur_tag = tag_q.pop_front();
                check(int'(act_len) == cur_len, cur_tag, longint'(act_len), cur_len);
            end else if (mon_pos != 0) begin
                check(int'(act_len) == cur_len, "R6", longint'(act_len), cur_len);
            end
            if (mon_pos == cur_len - 1 || mon_pos == cur_len)
                check(issue_en == (cmd_valid && mon_pos < cur_len), "R1",
                      longint'(issue_en), longint'(cmd_valid && mon_pos < cur_len));
            else
                check(issue_en == (cmd_valid && mon_pos < cur_len), "R2",
                      longint'(issue_en), longint'(cmd_valid && mon_pos < cur_len));
            mon_pos = (mon_pos + 1) % WIN;
        end
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R7: strobes during reset must not be counted
        rd_evt = 1'b1; wr_evt = 1'b1; cf_evt = 1'b1; cmd_valid = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        check(int'(act_len) == WIN, "R7", longint'(act_len), WIN);
        check(issue_en == 1'b1, "R7", longint'(issue_en), 1);
        @(negedge clk);
        rst = 1'b0;
        // first window: empty, budget below base -> shortened by gain*10 (R7 zero counts)
        run_window(0, 0, 0, 0, 16, "R7");
        run_window(0, 0, 0, 1000, 16, "R5");     // clipped at the top
        run_window(50, 20, 10, 250, 16, "R3");   // mixed counts
        run_window(30, 30, 0, 400, 8, "R4");     // fractional gain, positive error
        run_window(100, 100, 50, 200, 16, "R5"); // clipped at the bottom
        run_window(0, 0, 0, 400, 16, "R4");      // recovery upward
        run_window(1, 0, 0, 6, 8, "R3");         // single read in last cycle, floor of -3.5
        run_window(80, 80, 40, 600, 4, "R8");    // write and conflict strobes together
        run_window(0, 0, 0, 30, 16, "R4");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6", longint'(exp_q.size()), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule